// File: doc/BRIEF.md
# Boot ROM Shadow Copy Controller

This block sits between a CPU bus and a boot ROM and a RAM that both answer the same address window. It drives the active-low output enable of the ROM, and the output enable and write enable of the RAM. It also drives a wait request back to the CPU. A single mode bit selects one of two behaviours.

The block leaves reset in copy mode. In copy mode, a CPU read anywhere in the window is answered by the ROM, and the RAM is strobed to write the same bus data at the same address. Software makes a RAM image of the ROM with a simple loop that reads each location once. Each copy-mode read is stretched by one wait state, so the data on the bus has settled before the RAM write strobe is asserted.

Software then writes a control register to select run mode. In run mode the ROM is silent and the RAM acts as ordinary read/write memory with no wait states. The mode change is held until no bus strobe is active, so it never lands in the middle of a cycle.

Top module: `shadow_boot_ctl`

## Requirements
- R1: After reset the block is in copy mode; with both strobes inactive, romOeN, ramOeN and ramWeN are high and waitReq is low.
- R2: In copy mode, a read inside the window (rdN low) drives romOeN low in the same cycle and keeps ramOeN high.
- R3: In copy mode, the first clock cycle of a read at an address asserts waitReq and keeps ramWeN high. Each following cycle of that read at the same address drops waitReq and drives ramWeN low.
- R4: ramWeN returns high in the same cycle that rdN returns high, never later.
- R5: Back-to-back copy-mode reads at a new address, with no idle cycle between them, each get a fresh wait state before ramWeN is asserted.
- R6: In copy mode, a CPU write (wrN low) inside the window leaves ramWeN, ramOeN and romOeN high and waitReq low.
- R7: In run mode, romOeN stays high, ramOeN follows rdN, ramWeN follows wrN inside the window, and waitReq stays low.
- R8: Accesses outside the window [WIN_BASE, WIN_BASE+WIN_SIZE) leave all three enables high and waitReq low in either mode.
- R9: A write (wrN low) at CTL_ADDR captures ctlData as the new mode (1 = run, 0 = copy). The new mode takes effect on the clock edge after the first cycle in which rdN and wrN are both high. Window accesses in between still use the old mode.
- R10: A control write of 0 returns the block from run mode to copy mode, and copy-mode reads are stretched again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | CPU address |
| rdN | input | 1 | CPU read strobe, active low |
| wrN | input | 1 | CPU write strobe, active low |
| ctlData | input | 1 | Bus data line carrying the mode bit on control writes |
| romOeN | output | 1 | ROM output enable, active low |
| ramOeN | output | 1 | RAM output enable, active low |
| ramWeN | output | 1 | RAM write enable, active low |
| waitReq | output | 1 | Wait request to the CPU, high inserts a wait state |

## Verification
A behavioural reference in the bench tracks the mode, the pending mode write and the wait flip-flop, and it is compared with all four outputs on every clock. Single stretched reads separate the wait cycle from the write-under cycle. Back-to-back reads at changing addresses show whether the wait flip-flop is re-armed for each new location. A copy loop over a block of addresses exercises the normal use. Control writes that are followed at once by window reads, before any idle cycle, show whether the mode changes too early. Writes in copy mode, accesses outside the window and a return to copy mode cover the cases where the enables must stay quiet.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  // Strobes from the control side to the output datapath, all active high.
  typedef struct packed {
    logic romRd;    // ROM drives the bus
    logic ramRd;    // RAM drives the bus
    logic ramWr;    // RAM latches the bus
    logic waitHold; // stretch the current cycle
  } strobeT;
endpackage

// File: rtl/shadow_ctl_fsm.sv
module shadow_ctl_fsm
  import shadow_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              inWin,
  input  logic              ctlHit,
  input  logic              rdAct,
  input  logic              wrAct,
  input  logic              ctlData,
  output strobeT            strb,
  output logic              modeRun
);
  logic              waitQ;     // wait state already served
  logic [ADDR_W-1:0] heldQ;     // address the wait state was served for
  logic              pendQ;     // mode write waiting for an idle bus
  logic              pendBitQ;
  logic              copyRd;
  logic              waitDone;
  logic              busIdle;

  assign copyRd   = inWin & rdAct & ~modeRun;
  assign waitDone = waitQ & (heldQ == addr);
  assign busIdle  = ~rdAct & ~wrAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitQ    <= 1'b0;
      heldQ    <= '0;
      pendQ    <= 1'b0;
      pendBitQ <= 1'b0;
      modeRun  <= 1'b0;
    end else begin
      waitQ <= copyRd;
      if (copyRd) heldQ <= addr;
      if (ctlHit && wrAct) begin
        pendQ    <= 1'b1;
        pendBitQ <= ctlData;
      end else if (busIdle && pendQ) begin
        modeRun <= pendBitQ;
        pendQ   <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.romRd    = copyRd;
    strb.ramRd    = inWin & rdAct & modeRun;
    strb.ramWr    = modeRun ? (inWin & wrAct) : (copyRd & waitDone);
    strb.waitHold = copyRd & ~waitDone;
  end
endmodule

// File: rtl/shadow_strobe_path.sv
module shadow_strobe_path
  import shadow_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = '0,
  parameter int unsigned     WIN_SIZE = 16384,
  parameter logic [ADDR_W-1:0] CTL_ADDR = '1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdN,
  input  logic              wrN,
  input  strobeT            strb,
  output logic              inWin,
  output logic              ctlHit,
  output logic              rdAct,
  output logic              wrAct,
  output logic              romOeN,
  output logic              ramOeN,
  output logic              ramWeN,
  output logic              waitReq
);
  localparam logic [ADDR_W:0] WIN_END = (ADDR_W+1)'(WIN_BASE) + (ADDR_W+1)'(WIN_SIZE);

  logic belowEnd;
  assign belowEnd = {1'b0, addr} < WIN_END;

  generate
    if (WIN_BASE == '0) begin : g_base_zero
      assign inWin = belowEnd;
    end else begin : g_base_any
      assign inWin = (addr >= WIN_BASE) & belowEnd;
    end
  endgenerate

  assign ctlHit = (addr == CTL_ADDR);
  assign rdAct  = ~rdN;
  assign wrAct  = ~wrN;

  assign romOeN  = ~strb.romRd;
  assign ramOeN  = ~strb.ramRd;
  assign ramWeN  = ~strb.ramWr;
  assign waitReq = strb.waitHold;
endmodule

// File: rtl/shadow_boot_ctl.sv
module shadow_boot_ctl
  import shadow_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = '0,
  parameter int unsigned       WIN_SIZE = 16384,
  parameter logic [ADDR_W-1:0] CTL_ADDR = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              ctlData,
  output logic              romOeN,
  output logic              ramOeN,
  output logic              ramWeN,
  output logic              waitReq
);
  strobeT strb;
  logic   inWin, ctlHit, rdAct, wrAct, modeRun;

  shadow_strobe_path #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE), .CTL_ADDR(CTL_ADDR)
  ) path_i (
    .addr(addr), .rdN(rdN), .wrN(wrN), .strb(strb),
    .inWin(inWin), .ctlHit(ctlHit), .rdAct(rdAct), .wrAct(wrAct),
    .romOeN(romOeN), .ramOeN(ramOeN), .ramWeN(ramWeN), .waitReq(waitReq)
  );

  shadow_ctl_fsm #(.ADDR_W(ADDR_W)) ctl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .inWin(inWin), .ctlHit(ctlHit),
    .rdAct(rdAct), .wrAct(wrAct), .ctlData(ctlData), .strb(strb), .modeRun(modeRun)
  );
endmodule

// File: rtl/shadow_boot_ctl_chk.sv
module shadow_boot_ctl_chk #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = '0,
  parameter int unsigned       WIN_SIZE = 16384
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              rdN,
  input logic              wrN,
  input logic              romOeN,
  input logic              ramOeN,
  input logic              ramWeN,
  input logic              waitReq,
  input logic              modeRun
);
  localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(WIN_BASE);
  localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(WIN_BASE) + (ADDR_W+1)'(WIN_SIZE);

  logic outside;
  assign outside = ({1'b0, addr} < LO) || ({1'b0, addr} >= HI);

  // R2 / R7: ROM and RAM never drive the bus together
  p_one_driver_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ramOeN |-> romOeN);

  // R4: RAM write strobe never outlasts both CPU strobes
  p_we_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdN && wrN) |-> ramWeN);

  // R3: a write-under strobe follows a read cycle at the same address
  p_we_after_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ramWeN && !romOeN) |-> ($past(!rdN) && $past(addr) == addr));

  // R3: once a wait state is served, the same read is not stretched again
  p_single_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    (waitReq && !rdN) ##1 (!rdN && $stable(addr)) |-> !waitReq);

  // R8: no enables and no wait outside the window
  p_outside_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    outside |-> (romOeN && ramOeN && ramWeN && !waitReq));

  // R9: the mode bit holds across any cycle with a strobe active
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(rdN && wrN) |=> $stable(modeRun));
endmodule

bind shadow_boot_ctl shadow_boot_ctl_chk #(
  .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
) chk_i (.*);

// File: tb/shadow_boot_ctl_tb_top.sv
module shadow_boot_ctl_tb_top;
  localparam int ADDR_W = 16;
  localparam int WSIZE  = 16384;
  localparam logic [15:0] CTL = 16'hF000;

  logic clk = 0, rstN = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic rdN = 1, wrN = 1, ctlData = 0;
  logic romOeN, ramOeN, ramWeN, waitReq;

  int compared = 0, mismatched = 0;
  string curTag = "R1";

  // reference state
  int mMode = 0, mWait = 0, mHeld = 0, mPend = 0, mPendBit = 0;

  always #4 clk = ~clk;

  shadow_boot_ctl #(.ADDR_W(ADDR_W), .WIN_SIZE(WSIZE), .CTL_ADDR(CTL)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .rdN(rdN), .wrN(wrN), .ctlData(ctlData),
    .romOeN(romOeN), .ramOeN(ramOeN), .ramWeN(ramWeN), .waitReq(waitReq));

  function automatic bit inWinF(input int a);
    return a < WSIZE;
  endfunction

  function automatic bit copyRead();
    return inWinF(int'(addr)) && !rdN && mMode == 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mWait = 0; mHeld = 0; mPend = 0; mPendBit = 0;
    end else begin
      bit cr;
      cr = copyRead();
      if (cr) mHeld = int'(addr);
      mWait = cr;
      if (!wrN && addr == CTL) begin
        mPend = 1; mPendBit = ctlData;
      end else if (rdN && wrN && mPend == 1) begin
        mMode = mPendBit; mPend = 0;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare with the reference away from the active edge
  always @(negedge clk) begin
    bit cr, done, w, eRom, eRamOe, eWe, eWait;
    cr   = copyRead();
    done = (mWait == 1) && (mHeld == int'(addr));
    w    = inWinF(int'(addr));
    eRom   = !cr;
    eRamOe = !(w && !rdN && mMode == 1);
    eWe    = (mMode == 1) ? !(w && !wrN) : !(cr && done);
    eWait  = cr && !done;
    chk(curTag, "romOeN", romOeN, eRom);
    chk(curTag, "ramOeN", ramOeN, eRamOe);
    chk(curTag, "ramWeN", ramWeN, eWe);
    chk(curTag, "waitReq", waitReq, eWait);
  end

  task automatic bus(input logic [15:0] a, input logic r, input logic wr, input logic d, input int n);
    addr = a; rdN = r; wrN = wr; ctlData = d;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    bus(16'h0000, 1, 1, 0, n);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    // R1: reset state
    curTag = "R1";
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    idle(2);
    @(negedge clk);
    chk("R1", "romOeN idle", romOeN, 1'b1);
    chk("R1", "waitReq idle", waitReq, 1'b0);
    @(posedge clk); #1;

    // R2, R3, R4: one stretched copy read then release
    curTag = "R2_R3";
    bus(16'h0010, 0, 1, 0, 1);
    bus(16'h0010, 0, 1, 0, 2);
    curTag = "R4";
    idle(1);

    // R5: back-to-back reads at new addresses
    curTag = "R5";
    for (int i = 0; i < 4; i++) bus(16'h0020 + 16'(i), 0, 1, 0, 2);
    idle(1);

    // R3: copy loop over a block of locations
    curTag = "R3";
    for (int i = 0; i < 64; i++) begin
      bus(16'h0100 + 16'(i), 0, 1, 0, 2);
      idle(1);
    end

    // R6: CPU writes ignored by the RAM in copy mode
    curTag = "R6";
    bus(16'h0030, 1, 0, 0, 3);
    idle(1);

    // R8: outside the window in copy mode
    curTag = "R8";
    bus(16'h8000, 0, 1, 0, 2);
    bus(16'h8002, 1, 0, 0, 2);
    idle(1);

    // R9: control write to run, then window reads before the bus goes idle
    curTag = "R9";
    bus(CTL, 1, 0, 1, 2);
    bus(16'h0040, 0, 1, 0, 2);
    bus(16'h0041, 0, 1, 0, 2);
    idle(2);

    // R7: run mode reads and writes
    curTag = "R7";
    bus(16'h0050, 0, 1, 0, 2);
    bus(16'h0051, 1, 0, 0, 2);
    idle(1);
    bus(16'h0052, 0, 1, 0, 1);
    bus(16'h0053, 1, 0, 0, 1);
    idle(1);
    curTag = "R8";
    bus(16'h9000, 0, 1, 0, 2);
    bus(16'h9000, 1, 0, 0, 2);
    idle(1);

    // R10: back to copy mode
    curTag = "R10";
    bus(CTL, 1, 0, 0, 1);
    idle(1);
    bus(16'h0060, 0, 1, 0, 2);
    idle(2);

    finishRun();
  end
endmodule